// File: doc/BRIEF.md
# Flag-Tested Relative Branch Resolver

This block decides conditional relative branches for a small 8-bit RISC core whose instructions are one 16-bit word. The decoder hands it a branch request, a 3-bit index that picks one of the eight status flags, a polarity bit and a 7-bit signed offset in words. The block reads the program counter, which counts words, and the 8-bit status register. Each mnemonic the core supports, such as branch-if-equal or branch-if-carry-set, is this generic test with a fixed flag index and a fixed polarity.

The taken flag, the next program counter and the cycle cost are combinational. A taken branch costs one cycle more than a fall-through. The block also raises a registered stall pulse in the cycle after a taken branch, and the core uses that pulse to hold fetch for that one extra cycle.

Top module: `flag_branch_unit`

## Requirements
- R1: With a request present, `taken` is 1 exactly when `sreg[br_sel]` equals `br_if_set`. Polarity 1 means branch if the flag is set, and 0 means branch if it is clear.
- R2: When taken, `pc_next` equals `pc_in + 1 + k`, where k is `br_off` read as a two's-complement number from -64 to +63.
- R3: When not taken, `pc_next` equals `pc_in + 1`.
- R4: `cycles` is 2 on a taken branch and 1 otherwise. It never takes any other value.
- R5: With `br_req` low, `taken` is 0 and `pc_next` is `pc_in + 1`, whatever the flags, selector and offset are.
- R6: All target arithmetic wraps modulo 2^16. Examples: 0xFFFF + 1 gives 0x0000, and 0x0000 - 63 gives 0xFFC1.
- R7: `stall` is 0 after reset. It is 1 in the cycle after a cycle in which `taken` was 1 at the clock edge, and 0 after a cycle in which `taken` was 0.
- R8: Offset 7'h40 (-64) reaches `pc_in - 63`, and offset 7'h3F (+63) reaches `pc_in + 64`.
- R9: Flag positions in `sreg` from bit 0 up are carry, zero, negative, overflow, sign, half-carry, transfer and interrupt-enable. Branch-if-equal is selector 1 with polarity 1, branch-if-not-equal is selector 1 with polarity 0, and branch-if-lower (unsigned) is selector 0 with polarity 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset for the stall register |
| br_req | input | 1 | Decoded conditional branch present this cycle |
| br_sel | input | 3 | Index of the status flag to test |
| br_if_set | input | 1 | 1: branch if the flag is set; 0: branch if it is clear |
| br_off | input | 7 | Signed word offset |
| pc_in | input | 16 | Word address of the branch instruction |
| sreg | input | 8 | Status register |
| taken | output | 1 | Branch condition met |
| pc_next | output | 16 | Address of the next instruction to fetch |
| cycles | output | 2 | Cycle cost of this instruction |
| stall | output | 1 | Registered one-cycle stall after a taken branch |

## Verification
The bench uses the default parameters: a 16-bit word program counter, a 7-bit offset and an 8-bit status register. With these widths, directed cases can place the counter at 0x0000 and 0xFFFF and apply both offset extremes, so wraparound in both directions and the -63/+64 reach limits are covered. Random requests sweep all eight selectors against both polarities and arbitrary flag patterns. Back-to-back taken and untaken sequences drive the stall register through every transition.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int FLG_CARRY = 0;
  localparam int FLG_ZERO  = 1;
  localparam int FLG_NEG   = 2;
  localparam int FLG_OVF   = 3;
  localparam int FLG_SIGN  = 4;
  localparam int FLG_HALF  = 5;
  localparam int FLG_XFER  = 6;
  localparam int FLG_IEN   = 7;

  localparam int CYC_W     = 2;
  localparam logic [CYC_W-1:0] CYC_FALL  = 2'd1;
  localparam logic [CYC_W-1:0] CYC_TAKEN = 2'd2;
endpackage

// File: rtl/fbu_flag_pick.sv
module fbu_flag_pick #(
  parameter int FLAG_W = 8,
  localparam int SEL_W = $clog2(FLAG_W)
) (
  input  logic              req,
  input  logic [SEL_W-1:0]  sel,
  input  logic              if_set,
  input  logic [FLAG_W-1:0] flags,
  output logic              hit
);
  logic [FLAG_W-1:0] match_vec;

  genvar g;
  generate
    for (g = 0; g < FLAG_W; g++) begin : g_match
      assign match_vec[g] = (flags[g] == if_set);
    end
  endgenerate

  always_comb begin
    hit = req & match_vec[sel];
  end
endmodule

// File: rtl/fbu_pc_step.sv
module fbu_pc_step #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 7
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  input  logic             take,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  jump_pc,
  output logic [PC_W-1:0]  nxt
);
  localparam int EXT_W = PC_W - OFF_W;

  function automatic logic [PC_W-1:0] widen_off(input logic [OFF_W-1:0] o);
    return {{EXT_W{o[OFF_W-1]}}, o};
  endfunction

  function automatic logic [PC_W-1:0] step_one(input logic [PC_W-1:0] p);
    return p + {{(PC_W-1){1'b0}}, 1'b1};
  endfunction

  always_comb begin
    seq_pc  = step_one(pc);
    jump_pc = seq_pc + widen_off(off);
    nxt     = take ? jump_pc : seq_pc;
  end
endmodule

// File: rtl/fbu_stall_reg.sv
module fbu_stall_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic stall
);
  always_ff @(posedge clk) begin
    if (!rst_n) stall <= 1'b0;
    else        stall <= take;
  end
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit #(
  parameter int PC_W   = 16,
  parameter int OFF_W  = 7,
  parameter int FLAG_W = 8,
  localparam int SEL_W = $clog2(FLAG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_req,
  input  logic [SEL_W-1:0]  br_sel,
  input  logic              br_if_set,
  input  logic [OFF_W-1:0]  br_off,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [FLAG_W-1:0] sreg,
  output logic              taken,
  output logic [PC_W-1:0]   pc_next,
  output logic [1:0]        cycles,
  output logic              stall
);
  import fbu_pkg::*;

  logic            cond_hit;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] jump_pc;

  fbu_flag_pick #(.FLAG_W(FLAG_W)) u_pick (
    .req(br_req), .sel(br_sel), .if_set(br_if_set), .flags(sreg), .hit(cond_hit)
  );

  fbu_pc_step #(.PC_W(PC_W), .OFF_W(OFF_W)) u_step (
    .pc(pc_in), .off(br_off), .take(cond_hit),
    .seq_pc(seq_pc), .jump_pc(jump_pc), .nxt(pc_next)
  );

  fbu_stall_reg u_stall (
    .clk(clk), .rst_n(rst_n), .take(cond_hit), .stall(stall)
  );

  always_comb begin
    taken  = cond_hit;
    cycles = cond_hit ? CYC_TAKEN : CYC_FALL;
  end

  AST_TAKEN_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (sreg[br_sel] == br_if_set)); // R1
  AST_NO_REQ_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !br_req |-> !taken); // R5
  AST_FALL_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> (pc_next == pc_in + 1'b1)); // R3
  AST_CYCLE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cycles == 2'd1) || (cycles == 2'd2)); // R4
  AST_STALL_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> stall); // R7
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> !stall); // R7
endmodule

// File: tb/flag_branch_unit_tb.sv
module flag_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_req = 1'b0;
  logic [2:0]  br_sel = '0;
  logic        br_if_set = 1'b0;
  logic [6:0]  br_off = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  sreg = '0;
  logic        taken;
  logic [15:0] pc_next;
  logic [1:0]  cycles;
  logic        stall;

  int n_run = 0;
  int n_fail = 0;
  logic prev_exp_take = 1'b0;
  logic stall_armed = 1'b0;

  always #2 clk = ~clk;

  flag_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .br_req(br_req), .br_sel(br_sel),
    .br_if_set(br_if_set), .br_off(br_off), .pc_in(pc_in), .sreg(sreg),
    .taken(taken), .pc_next(pc_next), .cycles(cycles), .stall(stall)
  );

  function automatic logic want_take(input logic rq, input logic [2:0] s,
                                     input logic pol, input logic [7:0] f);
    logic bitv;
    bitv = (f >> s) & 8'd1;
    return rq && (bitv == pol);
  endfunction

  function automatic logic [15:0] want_pc(input logic tk, input logic [15:0] p,
                                          input logic [6:0] o);
    int k;
    int t;
    k = (o >= 7'd64) ? int'(o) - 128 : int'(o);
    t = int'(p) + 1 + (tk ? k : 0);
    t = ((t % 65536) + 65536) % 65536;
    return t[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic rq, input logic [2:0] s, input logic pol,
                       input logic [6:0] o, input logic [15:0] p, input logic [7:0] f,
                       input string tag);
    logic et;
    @(negedge clk);
    if (stall_armed) check("R7 stall", {31'd0, stall}, {31'd0, prev_exp_take});
    br_req = rq; br_sel = s; br_if_set = pol; br_off = o; pc_in = p; sreg = f;
    #1;
    et = want_take(rq, s, pol, f);
    check({tag, " taken"}, {31'd0, taken}, {31'd0, et});
    check({tag, " pc_next"}, {16'd0, pc_next}, {16'd0, want_pc(et, p, o)});
    check("R4 cycles", {30'd0, cycles}, et ? 32'd2 : 32'd1);
    prev_exp_take = et;
    stall_armed = 1'b1;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset stall", {31'd0, stall}, 32'd0);
    rst_n = 1'b1;

    // R9 named conditions: equal (Z set), not-equal (Z clear), lower (C set)
    apply(1'b1, 3'd1, 1'b1, 7'd5, 16'h0100, 8'b0000_0010, "R9 equal");
    apply(1'b1, 3'd1, 1'b0, 7'd5, 16'h0100, 8'b0000_0010, "R9 not-equal");
    apply(1'b1, 3'd0, 1'b1, 7'h7E, 16'h0200, 8'b0000_0001, "R9 lower");
    apply(1'b1, 3'd0, 1'b1, 7'h7E, 16'h0200, 8'b1111_1110, "R9 lower-miss");
    // R8 reach extremes
    apply(1'b1, 3'd7, 1'b1, 7'h40, 16'h1000, 8'h80, "R8 min");
    apply(1'b1, 3'd7, 1'b1, 7'h3F, 16'h1000, 8'h80, "R8 max");
    // R6 wrap both ways
    apply(1'b1, 3'd6, 1'b0, 7'h40, 16'h0000, 8'h00, "R6 wrap down");
    apply(1'b1, 3'd6, 1'b0, 7'h3F, 16'hFFFF, 8'h00, "R6 wrap up");
    apply(1'b1, 3'd6, 1'b1, 7'h3F, 16'hFFFF, 8'h00, "R3 R6 fall wrap");
    // R5 no request with every flag condition otherwise met
    apply(1'b0, 3'd2, 1'b1, 7'h3F, 16'h1234, 8'hFF, "R5 idle set");
    apply(1'b0, 3'd2, 1'b0, 7'h40, 16'h1234, 8'h00, "R5 idle clear");
    // R7 back-to-back taken then not taken
    apply(1'b1, 3'd4, 1'b1, 7'd1, 16'h0040, 8'h10, "R2 seq1");
    apply(1'b1, 3'd4, 1'b1, 7'd2, 16'h0041, 8'h10, "R2 seq2");
    apply(1'b1, 3'd4, 1'b1, 7'd2, 16'h0042, 8'h00, "R3 seq3");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] f;
      f = 8'($urandom);
      apply(($urandom % 8) != 0, 3'($urandom), 1'($urandom), 7'($urandom),
            16'($urandom), f, "R1 R2 R3 random");
    end
    @(negedge clk);
    check("R7 stall tail", {31'd0, stall}, {31'd0, prev_exp_take});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule